// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block controls a four-channel converter front end in which every channel is sampled at the same instant. A host writes a 4-bit mode word over a small parallel bus that uses active-low chip-select and write strobes. The mode word selects one of two input banks and sets how many channels, from one to four, are converted after each trigger. A separate code in the same word puts the block into power-down, where triggers are ignored.

A rising edge on the asynchronous convert-start input tells all four track/holds to hold. The block then converts channels one after another, starting with channel 1. For each channel it raises a busy window of a fixed number of clock cycles, the modelled conversion time. At the end of that window it stores the 14-bit code on the converter port into a four-entry result store. After the last channel, the active-low interrupt falls and the track/holds go back to tracking. The programmed mode applies to every later trigger until a new word is written. The result store can be read at any time through an index port.

Top module: `sim_sample_seq`

## Requirements
- R1: After reset, `int_n` is 1 and `th_hold`, `seq_busy`, `ch_active`, `bank_b` and `sleep` are all 0. The mode is bank A with one channel.
- R2: In a mode word with bit 3 = 0, bits 1:0 give the channel count minus one (00 = one channel, 11 = four channels). Bit 2 selects bank A (0) or bank B (1), and `bank_b` shows the selected bank.
- R3: A word is taken from `bus_data` as it stood at the first rise of `cs_n` or `wr_n` while both were low. A write strobe with `cs_n` high changes nothing.
- R4: A word with bit 3 = 1 raises `sleep` and keeps the bank and count. While `sleep` is 1, convert-start is ignored. A later word with bit 3 = 0 clears `sleep` and applies bits 2:0.
- R5: `conv_start` passes through a two-flop synchronizer. `th_hold` and `seq_busy` rise after the third clock edge that follows a rising `conv_start`. At that same edge `int_n` returns to 1.
- R6: Channels are converted in order starting at channel 1. Exactly one `ch_active` bit is high during a sequence, and each bit stays high for exactly CONV_CLKS cycles.
- R7: Result entry i holds the `adc_code` value present in the last cycle of channel i's window. Entries beyond the programmed count keep their old contents. `rd_data` shows entry `rd_sel`.
- R8: `th_hold` and `seq_busy` fall and `int_n` falls at the same edge. This happens N×CONV_CLKS cycles after `th_hold` rose, where N is the programmed count.
- R9: A convert-start edge that arrives while a sequence runs is ignored and does not start another sequence.
- R10: The programmed mode applies to every later trigger until a new word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Bus chip-select, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| bus_data | input | 4 | Mode word from the host |
| conv_start | input | 1 | Asynchronous convert trigger; its rising edge starts a sequence |
| adc_code | input | 14 | Result code from the modelled converter |
| rd_sel | input | 2 | Result-store entry to read |
| th_hold | output | 1 | Hold command to all four track/holds |
| seq_busy | output | 1 | High from the sampling edge until the interrupt falls |
| ch_active | output | 4 | One-hot conversion-busy window per channel |
| bank_b | output | 1 | Selected input bank (1 = bank B) |
| sleep | output | 1 | Power-down state |
| int_n | output | 1 | End-of-sequence interrupt, active low |
| rd_data | output | 14 | Contents of the selected result entry |

## Verification
The hardest situation to reach from the ports is a second convert-start edge that arrives while a sequence is running. It must pass through the synchronizer and be dropped without shortening or restarting the run. The bench produces this by pulsing `conv_start` again part-way through a four-channel sequence. It then checks the total hold length, the order of the channels, and that the block stays idle afterwards. A second hard case is a bus cycle in which the data changes between the two strobe rises. The bench releases `cs_n` first in one test and `wr_n` first in another, changing `bus_data` between the two releases.

// File: rtl/seq_pkg.sv
// Shared constants and types for the conversion sequencer.
// Assumes four track/hold channels and a 4-bit mode word.
package seq_pkg;
    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int RES_W  = 14;
    localparam int MODE_W = 4;

    typedef struct packed {
        logic            sleep;
        logic            bank_b;
        logic [CH_W-1:0] last_ch;
    } mode_t;

    localparam mode_t MODE_RESET = '{sleep: 1'b0, bank_b: 1'b0, last_ch: '0};
endpackage

// File: rtl/seq_mode_reg.sv
// Mode register written over the strobed parallel bus.
// Assumes cs_n and wr_n are already synchronous to clk. The word that was on
// the bus in the last cycle with both strobes low is applied in the cycle
// after either strobe rises.
module seq_mode_reg
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [MODE_W-1:0] bus_data,
    output mode_t             mode
);
    logic              act_now;
    logic              act_q;
    logic [MODE_W-1:0] word_q;
    logic              capture;

    assign act_now = ~cs_n & ~wr_n;
    assign capture = act_q & ~act_now;

    // Track the active strobe phase and hold the last word seen in it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            word_q <= '0;
        end else begin
            act_q <= act_now;
            if (act_now) word_q <= bus_data;
        end
    end

    // Apply the captured word; a power-down word keeps bank and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_RESET;
        end else if (capture) begin
            mode.sleep <= word_q[3];
            if (!word_q[3]) begin
                mode.bank_b  <= word_q[2];
                mode.last_ch <= word_q[CH_W-1:0];
            end
        end
    end
endmodule

// File: rtl/seq_start_sync.sv
// Two-flop synchronizer with rising-edge detection for the convert trigger.
// Assumes each trigger pulse lasts at least two clock periods high and low.
module seq_start_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_rise
);
    logic [2:0] sync_q;

    // Shift the asynchronous trigger through the sync chain plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], trig_async};
    end

    assign trig_rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/seq_ctrl.sv
// Sequence controller. An accepted trigger holds all channels, then steps
// through channels 0..last. Each channel lasts CONV_CLKS cycles, and one
// store write happens in the last cycle of each channel. Assumes CONV_CLKS >= 2.
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int CONV_CLKS = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_rise,
    input  mode_t           mode,
    output logic            busy,
    output logic            int_n,
    output logic [NCH-1:0]  ch_active,
    output logic            wr_en,
    output logic [CH_W-1:0] wr_idx
);
    localparam int CNT_W = $clog2(CONV_CLKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  ch_q;
    logic [CH_W-1:0]  last_q;
    logic             cnt_end;

    assign cnt_end = (cnt_q == CNT_W'(CONV_CLKS - 1));

    // Accept a trigger when idle and awake; step channels; finish with interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            int_n  <= 1'b1;
            cnt_q  <= '0;
            ch_q   <= '0;
            last_q <= '0;
        end else if (!busy) begin
            if (trig_rise && !mode.sleep) begin
                busy   <= 1'b1;
                int_n  <= 1'b1;
                cnt_q  <= '0;
                ch_q   <= '0;
                last_q <= mode.last_ch;
            end
        end else if (cnt_end) begin
            cnt_q <= '0;
            if (ch_q == last_q) begin
                busy  <= 1'b0;
                int_n <= 1'b0;
            end else begin
                ch_q <= ch_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Per-channel busy windows decoded from the channel pointer.
    for (genvar i = 0; i < NCH; i++) begin : g_win
        assign ch_active[i] = busy && (ch_q == CH_W'(i));
    end

    assign wr_en  = busy && cnt_end;
    assign wr_idx = ch_q;
endmodule

// File: rtl/seq_result_store.sv
// Result store with one entry per channel, one write port and one read port
// that reads without a clock. Entries reset to zero.
module seq_result_store
    import seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_idx,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_idx,
    output logic [RES_W-1:0] rd_data
);
    logic [RES_W-1:0] mem_q [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ent
        // Load this entry when its channel finishes converting.
        always_ff @(posedge clk) begin
            if (!rst_n)                               mem_q[i] <= '0;
            else if (wr_en && wr_idx == CH_W'(i))     mem_q[i] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/sim_sample_seq.sv
// Top of the simultaneous-sample conversion sequencer. It joins the bus mode
// register, the trigger synchronizer, the sequence controller and the result
// store. Assumes bus strobes are synchronous to clk and conv_start is not.
module sim_sample_seq
    import seq_pkg::*;
#(
    parameter int CONV_CLKS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [3:0]        bus_data,
    input  logic              conv_start,
    input  logic [13:0]       adc_code,
    input  logic [1:0]        rd_sel,
    output logic              th_hold,
    output logic              seq_busy,
    output logic [3:0]        ch_active,
    output logic              bank_b,
    output logic              sleep,
    output logic              int_n,
    output logic [13:0]       rd_data
);
    mode_t           mode;
    logic            trig_rise;
    logic            busy;
    logic            wr_en;
    logic [CH_W-1:0] wr_idx;

    seq_mode_reg i_mode (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .bus_data(bus_data), .mode(mode)
    );

    seq_start_sync i_sync (
        .clk(clk), .rst_n(rst_n), .trig_async(conv_start), .trig_rise(trig_rise)
    );

    seq_ctrl #(.CONV_CLKS(CONV_CLKS)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise), .mode(mode),
        .busy(busy), .int_n(int_n), .ch_active(ch_active),
        .wr_en(wr_en), .wr_idx(wr_idx)
    );

    seq_result_store i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(adc_code), .rd_idx(rd_sel), .rd_data(rd_data)
    );

    assign th_hold  = busy;
    assign seq_busy = busy;
    assign bank_b   = mode.bank_b;
    assign sleep    = mode.sleep;
endmodule

// File: rtl/seq_checker.sv
// Property checker for sim_sample_seq, attached with bind. It counts the
// length of each channel window itself instead of using a deep $past.
module seq_checker #(
    parameter int CONV_CLKS = 48
) (
    input logic       clk,
    input logic       rst_n,
    input logic       th_hold,
    input logic       seq_busy,
    input logic [3:0] ch_active,
    input logic       sleep,
    input logic       int_n
);
    logic [15:0] win_cnt;
    logic [3:0]  prev_act;

    // Measure how many cycles the current channel window has lasted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            prev_act <= '0;
        end else begin
            if (ch_active != 4'b0 && ch_active == prev_act) win_cnt <= win_cnt + 1'b1;
            else if (ch_active != 4'b0)                     win_cnt <= 16'd1;
            else                                            win_cnt <= '0;
            prev_act <= ch_active;
        end
    end

    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_active) && (seq_busy == ($countones(ch_active) == 1)));

    a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_act != 4'b0 && ch_active != prev_act) |-> win_cnt == 16'(CONV_CLKS));

    a_r8_end_together: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_busy) |-> (!int_n && !th_hold));

    a_r5_start_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> (int_n && th_hold && ch_active == 4'b0001));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_active[0]) |-> $rose(seq_busy));

    a_r4_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !seq_busy) |=> !seq_busy);
endmodule

bind sim_sample_seq seq_checker #(.CONV_CLKS(CONV_CLKS)) i_chk (
    .clk(clk), .rst_n(rst_n), .th_hold(th_hold), .seq_busy(seq_busy),
    .ch_active(ch_active), .sleep(sleep), .int_n(int_n)
);

// File: tb/test_sim_sample_seq.sv
// Directed bench for sim_sample_seq: one task per scenario, each checking itself.
module test_sim_sample_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CONV       = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [3:0]  bus_data = '0;
    logic        conv_start = 1'b0;
    logic [13:0] adc_code;
    logic [1:0]  rd_sel = '0;
    logic        th_hold, seq_busy, bank_b, sleep, int_n;
    logic [3:0]  ch_active;
    logic [13:0] rd_data;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [11:0] run_tag = '0;
    logic [13:0] exp_store [4];

    sim_sample_seq #(.CONV_CLKS(CONV)) i_sim_sample_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .bus_data(bus_data),
        .conv_start(conv_start), .adc_code(adc_code), .rd_sel(rd_sel),
        .th_hold(th_hold), .seq_busy(seq_busy), .ch_active(ch_active),
        .bank_b(bank_b), .sleep(sleep), .int_n(int_n), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Converter model: the code carries the run tag and the active channel index.
    always_comb begin
        case (ch_active)
            4'b0010: adc_code = {run_tag, 2'd1};
            4'b0100: adc_code = {run_tag, 2'd2};
            4'b1000: adc_code = {run_tag, 2'd3};
            default: adc_code = {run_tag, 2'd0};
        endcase
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] word, input logic cs_first);
        @(negedge clk) begin cs_n = 1'b0; bus_data = word; end
        @(negedge clk) wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk) begin
            if (cs_first) cs_n = 1'b1; else wr_n = 1'b1;
            bus_data = ~word;
        end
        @(negedge clk) begin cs_n = 1'b1; wr_n = 1'b1; end
        @(negedge clk) bus_data = '0;
    endtask

    task automatic check_store(input string req);
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #1;
            check(rd_data === exp_store[i], req, int'(rd_data), int'(exp_store[i]));
        end
    endtask

    // Trigger one sequence and check its timing, order and stored results.
    task automatic run_seq(input int n, input logic disturb, input string req);
        int hc = 0;
        int cnt [4] = '{0, 0, 0, 0};
        int nxt = 0;
        int order_bad = 0;
        logic [3:0] prev = '0;
        run_tag = run_tag + 12'h123;
        @(negedge clk) conv_start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(th_hold === 1'b0, "R5 no hold after two edges", int'(th_hold), 0);
        @(negedge clk);
        check(th_hold === 1'b1 && seq_busy === 1'b1, "R5 hold after third edge", int'(th_hold), 1);
        check(int_n === 1'b1, "R5 int_n high at start", int'(int_n), 1);
        while (th_hold === 1'b1 && hc < 1000) begin
            hc++;
            for (int i = 0; i < 4; i++) if (ch_active[i]) cnt[i]++;
            if (ch_active != prev && ch_active != 4'b0) begin
                if (ch_active !== 4'(1 << nxt)) order_bad++;
                nxt++;
            end
            prev = ch_active;
            if (hc == 4) conv_start = 1'b0;
            if (disturb && hc == 20) conv_start = 1'b1;
            if (disturb && hc == 26) conv_start = 1'b0;
            @(negedge clk);
        end
        check(hc == n * CONV, {req, " R8 hold length"}, hc, n * CONV);
        check(int_n === 1'b0 && seq_busy === 1'b0, "R8 int_n low at end", int'(int_n), 0);
        check(order_bad == 0 && nxt == n, "R6 channel order", nxt, n);
        for (int i = 0; i < 4; i++)
            check(cnt[i] == ((i < n) ? CONV : 0), "R6 window length", cnt[i], (i < n) ? CONV : 0);
        repeat (10) @(negedge clk);
        check(seq_busy === 1'b0, "R9 stays idle after run", int'(seq_busy), 0);
        for (int i = 0; i < n; i++) exp_store[i] = {run_tag, 2'(i)};
        check_store("R7 store contents");
    endtask

    task automatic t_reset;
        check(int_n === 1'b1 && th_hold === 1'b0 && seq_busy === 1'b0, "R1 control outputs", int'(int_n), 1);
        check(ch_active === 4'b0 && bank_b === 1'b0 && sleep === 1'b0, "R1 mode outputs", int'(ch_active), 0);
        for (int i = 0; i < 4; i++) exp_store[i] = '0;
    endtask

    task automatic t_default_run;
        run_seq(1, 1'b0, "R1 default single");
    endtask

    task automatic t_four_wr_first;
        bus_write(4'b0011, 1'b0);
        check(bank_b === 1'b0 && sleep === 1'b0, "R3 wr-first capture bank", int'(bank_b), 0);
        run_seq(4, 1'b1, "R2 R9 four channels");
    endtask

    task automatic t_persist;
        run_seq(4, 1'b0, "R10 mode persists");
    endtask

    task automatic t_bank_b_cs_first;
        bus_write(4'b0110, 1'b1);
        check(bank_b === 1'b1, "R2 R3 cs-first bank B", int'(bank_b), 1);
        run_seq(3, 1'b0, "R2 three channels");
    endtask

    task automatic t_stray_write;
        @(negedge clk) bus_data = 4'b0000;
        @(negedge clk) wr_n = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk) wr_n = 1'b1;
        repeat (2) @(negedge clk);
        check(bank_b === 1'b1, "R3 write without cs ignored", int'(bank_b), 1);
        run_seq(3, 1'b0, "R3 count unchanged");
    endtask

    task automatic t_sleep;
        bus_write(4'b1000, 1'b0);
        check(sleep === 1'b1 && bank_b === 1'b1, "R4 sleep keeps bank", int'(sleep), 1);
        @(negedge clk) conv_start = 1'b1;
        repeat (4) @(negedge clk);
        conv_start = 1'b0;
        repeat (20) @(negedge clk);
        check(seq_busy === 1'b0 && th_hold === 1'b0, "R4 trigger ignored in sleep", int'(seq_busy), 0);
        check_store("R4 store untouched in sleep");
        bus_write(4'b0101, 1'b1);
        check(sleep === 1'b0 && bank_b === 1'b1, "R4 wake with new mode", int'(sleep), 0);
        run_seq(2, 1'b0, "R4 two channels after wake");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_run();
        t_four_wr_first();
        t_persist();
        t_bank_b_cs_first();
        t_stray_write();
        t_sleep();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule